// File: doc/BRIEF.md
# Flash busy status reporter

This block produces the read data and the ready/busy flag that a NOR flash array shows to its host while an internal program or erase is running. A stub counter stands in for the embedded operation: the operation starts on a one-cycle `op_start` pulse and lasts a fixed number of clock cycles, set per operation type by a parameter. While that counter runs, each read access returns a status word in place of the stored data. Bit 7 is the data-polling bit. Bit 6 is the toggle bit. The other bits pass the array data through. Once the operation ends, reads return the array word unchanged.

A read access is open while chip enable and output enable (both active low) are asserted together. The block captures the word once, on the clock edge where an access opens. It presents that word with `rd_valid` high until the access closes. Only this capture advances the toggle bit, so a host that holds a read open sees one steady value. A host that pulses either strobe sees bit 6 alternate. The ready/busy flag is an active-low level plus a drive enable, so several instances can share one wired-OR line.

Control has three sequencer states: `ST_IDLE`, `ST_PROGRAM` and `ST_ERASE`. An accepted start in `ST_IDLE` leads to `ST_PROGRAM` or `ST_ERASE`, chosen by `op_erase`. Either busy state returns to `ST_IDLE` when the counter expires. The read port has two states: `RP_QUIET` and `RP_ACCESS`. It moves from `RP_QUIET` to `RP_ACCESS` when both strobes are low, capturing the word on that edge. It moves back to `RP_QUIET` as soon as either strobe rises.

Top module: `flash_status_top`

## Requirements
- R1: When a read opens during a program, bit 7 of the captured word is the inverse of `op_poll_src` if `rd_addr` equals the address given with the start; otherwise bit 7 is the array's bit 7. Bits 5..0 are always the array's bits.
- R2: When a read opens during an erase, bit 7 of the captured word is 0 at any address, and bits 5..0 are the array's bits.
- R3: Within one operation, bit 6 of each read opened while busy is the inverse of bit 6 of the previous read opened during that operation. This holds whether the access was reopened by the chip-enable strobe or by the output-enable strobe.
- R4: A read opened while not busy captures exactly the array word, including bits 7 and 6.
- R5: After an accepted start, `rb_oe` is 1 and `rb_out_n` is 0 for exactly PROG_LEN cycles (program) or ERASE_LEN cycles (erase), counted from the first clock edge after the start. At all other times `rb_oe` is 0 and `rb_out_n` is 1.
- R6: A read that opens on the very first cycle after the start already returns the status word.
- R7: An `op_start` pulse during a busy operation is ignored. It does not lengthen the operation, change its type, or change the latched address or poll bit.
- R8: Holding an access open for several cycles neither recaptures the word nor advances the toggle bit.
- R9: `rd_valid` is 1 from the cycle after an access opens until the cycle after it closes, and `rd_data` is all zeros whenever `rd_valid` is 0.
- R10: During and right after reset the block is idle, `rb_oe` = 0, `rb_out_n` = 1, `rd_valid` = 0 and `rd_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_start | input | 1 | One-cycle request to begin an operation |
| op_erase | input | 1 | Operation type at start: 1 erase, 0 program |
| op_addr | input | AW | Address being programmed |
| op_poll_src | input | 1 | Bit 7 of the word being programmed |
| rd_ce_n | input | 1 | Chip enable of the read access, active low |
| rd_oe_n | input | 1 | Output enable of the read access, active low |
| rd_addr | input | AW | Read address |
| array_data | input | DW | True array contents at `rd_addr` |
| rd_data | output | DW | Captured read word, zero when not valid |
| rd_valid | output | 1 | Read word is being driven |
| rb_out_n | output | 1 | Ready/busy level, low while busy |
| rb_oe | output | 1 | Drive enable for the ready/busy line |

## Verification
The bench builds the block with PROG_LEN = 6 and ERASE_LEN = 11, and keeps the default AW = 19 and DW = 8. These short lengths let a random read sequence of one to three cycles on and one to two off span the whole busy window several times. Reads therefore land on the first busy cycle, on the final busy cycle, and in the first cycles after release. The short lengths also put the busy-to-idle edge inside held accesses and under stray start pulses. This is where the polling bit, the toggle bit and the release of the flag must stay consistent.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

    // Bit positions of the two end-of-operation signatures in the read word
    localparam int POLL_BIT   = 7;
    localparam int TOGGLE_BIT = 6;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PROGRAM = 2'd1,
        ST_ERASE   = 2'd2
    } fs_state_e;

    typedef enum logic {
        RP_QUIET  = 1'b0,
        RP_ACCESS = 1'b1
    } rp_state_e;

endpackage

// File: rtl/fs_op_timer.sv
module fs_op_timer #(
    parameter int PROG_LEN  = 30,
    parameter int ERASE_LEN = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic load_erase,
    input  logic active,
    output logic expire
);
    localparam int MAXLEN = (PROG_LEN > ERASE_LEN) ? PROG_LEN : ERASE_LEN;
    localparam int CW     = (MAXLEN > 2) ? $clog2(MAXLEN) : 1;
    localparam logic [CW-1:0] PROG_LAST  = CW'(PROG_LEN - 1);
    localparam logic [CW-1:0] ERASE_LAST = CW'(ERASE_LEN - 1);
    localparam logic [CW-1:0] MAX_LAST   = CW'(MAXLEN - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_erase ? ERASE_LAST : PROG_LAST;
        end else if (active && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = active && (cnt_q == '0);

    // The remaining count never exceeds the longest programmed length
    assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt_q <= MAX_LAST));

    // While counting, the count falls by one each cycle until it expires
    assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !expire && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/fs_seq.sv
module fs_seq
    import flash_status_pkg::*;
#(
    parameter int AW = 19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_start,
    input  logic          op_erase,
    input  logic [AW-1:0] op_addr,
    input  logic          op_poll_src,
    input  logic          expire,
    output logic          busy,
    output logic          erase_op,
    output logic          tmr_load,
    output logic          tmr_erase,
    output logic [AW-1:0] lat_addr,
    output logic          lat_poll
);
    fs_state_e state_q, state_d;
    logic      accept;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (op_start) begin
                    state_d = op_erase ? ST_ERASE : ST_PROGRAM;
                end
            end
            ST_PROGRAM: begin
                if (expire) begin
                    state_d = ST_IDLE;
                end
            end
            ST_ERASE: begin
                if (expire) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Operation context, captured only when a start is accepted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr <= '0;
            lat_poll <= 1'b0;
        end else if (accept) begin
            lat_addr <= op_addr;
            lat_poll <= op_poll_src;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        busy      = 1'b0;
        erase_op  = 1'b0;
        accept    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                accept = op_start;
            end
            ST_PROGRAM: begin
                busy = 1'b1;
            end
            ST_ERASE: begin
                busy     = 1'b1;
                erase_op = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
        tmr_load  = accept;
        tmr_erase = op_erase;
    end

    // R5: an expiring operation returns to idle on the next edge
    assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && expire) |=> (state_q == ST_IDLE));

    // R7: a start seen while busy leaves the captured context untouched
    assert_ignore_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_start) |=> ($stable(lat_addr) && $stable(lat_poll)));

    // R7: a busy operation keeps its type until it ends
    assert_kind_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !expire) |=> ($stable(erase_op) && busy));

endmodule

// File: rtl/fs_read_port.sv
module fs_read_port
    import flash_status_pkg::*;
#(
    parameter int AW = 19,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_ce_n,
    input  logic          rd_oe_n,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] array_data,
    input  logic          busy,
    input  logic          erase_op,
    input  logic [AW-1:0] lat_addr,
    input  logic          lat_poll,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    rp_state_e     rp_q, rp_d;
    logic          access;
    logic          capture;
    logic          tog_q;
    logic [DW-1:0] snap_q;
    logic [DW-1:0] status_word;

    assign access  = !rd_ce_n && !rd_oe_n;
    assign capture = (rp_q == RP_QUIET) && access;

    // Access tracking: next state
    always_comb begin
        rp_d = rp_q;
        unique case (rp_q)
            RP_QUIET:  if (access)  rp_d = RP_ACCESS;
            RP_ACCESS: if (!access) rp_d = RP_QUIET;
            default:   rp_d = RP_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rp_q <= RP_QUIET;
        end else begin
            rp_q <= rp_d;
        end
    end

    // Word offered to a read that opens in this cycle
    always_comb begin
        status_word = array_data;
        if (busy) begin
            if (erase_op) begin
                status_word[POLL_BIT] = 1'b0;
            end else if (rd_addr == lat_addr) begin
                status_word[POLL_BIT] = ~lat_poll;
            end
            status_word[TOGGLE_BIT] = ~tog_q;
        end
    end

    // Capture and toggle, both only on an opening access
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
            tog_q  <= 1'b0;
        end else if (capture) begin
            snap_q <= status_word;
            if (busy) begin
                tog_q <= ~tog_q;
            end
        end
    end

    // Outputs
    always_comb begin
        rd_valid = 1'b0;
        unique case (rp_q)
            RP_QUIET:  rd_valid = 1'b0;
            RP_ACCESS: rd_valid = 1'b1;
            default:   rd_valid = 1'b0;
        endcase
        rd_data = rd_valid ? snap_q : '0;
    end

    assert_idle_true_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !busy) |=> (rd_data == $past(array_data)));

    assert_erase_poll_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && busy && erase_op) |=> (rd_data[POLL_BIT] == 1'b0));

    assert_hit_poll_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && busy && !erase_op && (rd_addr == lat_addr))
        |=> (rd_data[POLL_BIT] == ~$past(lat_poll)));

    assert_held_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && access) |=> ($stable(rd_data) && $stable(tog_q)));

    assert_quiet_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0));

    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> rd_valid);

endmodule

// File: rtl/flash_status_top.sv
module flash_status_top #(
    parameter int AW        = 19,
    parameter int DW        = 8,
    parameter int PROG_LEN  = 30,
    parameter int ERASE_LEN = 500
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_start,
    input  logic          op_erase,
    input  logic [AW-1:0] op_addr,
    input  logic          op_poll_src,
    input  logic          rd_ce_n,
    input  logic          rd_oe_n,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] array_data,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic          rb_out_n,
    output logic          rb_oe
);
    logic          busy;
    logic          erase_op;
    logic          tmr_load;
    logic          tmr_erase;
    logic          expire;
    logic [AW-1:0] lat_addr;
    logic          lat_poll;

    fs_seq #(.AW(AW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_start    (op_start),
        .op_erase    (op_erase),
        .op_addr     (op_addr),
        .op_poll_src (op_poll_src),
        .expire      (expire),
        .busy        (busy),
        .erase_op    (erase_op),
        .tmr_load    (tmr_load),
        .tmr_erase   (tmr_erase),
        .lat_addr    (lat_addr),
        .lat_poll    (lat_poll)
    );

    fs_op_timer #(.PROG_LEN(PROG_LEN), .ERASE_LEN(ERASE_LEN)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (tmr_load),
        .load_erase (tmr_erase),
        .active     (busy),
        .expire     (expire)
    );

    fs_read_port #(.AW(AW), .DW(DW)) u_rp (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_ce_n    (rd_ce_n),
        .rd_oe_n    (rd_oe_n),
        .rd_addr    (rd_addr),
        .array_data (array_data),
        .busy       (busy),
        .erase_op   (erase_op),
        .lat_addr   (lat_addr),
        .lat_poll   (lat_poll),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid)
    );

    // Ready/busy: drive the line low for the whole operation, release otherwise
    assign rb_oe    = busy;
    assign rb_out_n = ~busy;

    assert_rb_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rb_oe && op_start) |=> (rb_oe && !rb_out_n));

    assert_rb_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_oe && expire) |=> (!rb_oe && rb_out_n));

endmodule

// File: tb/sim_flash_status_top.sv
module sim_flash_status_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 19;
    localparam int DW         = 8;
    localparam int PROG_LEN   = 6;
    localparam int ERASE_LEN  = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_start = 1'b0;
    logic          op_erase = 1'b0;
    logic [AW-1:0] op_addr = '0;
    logic          op_poll_src = 1'b0;
    logic          rd_ce_n = 1'b1;
    logic          rd_oe_n = 1'b1;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] array_data = '0;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic          rb_out_n;
    logic          rb_oe;
    logic          rb_line;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;
    string ctx = "";

    // Bench model state
    bit            m_busy = 0;
    bit            m_erase = 0;
    int            m_cnt = 0;
    logic [AW-1:0] m_addr = '0;
    logic          m_poll = 1'b0;
    bit            m_accq = 0;
    logic [DW-1:0] m_snap = '0;
    bit            m_snap_busy = 0;
    bit            m_snap_erase = 0;
    bit            cap_now = 0;
    bit            have_prev = 0;
    logic          prev_b6 = 1'b0;

    flash_status_top #(.AW(AW), .DW(DW), .PROG_LEN(PROG_LEN), .ERASE_LEN(ERASE_LEN)) u0 (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_erase(op_erase),
        .op_addr(op_addr), .op_poll_src(op_poll_src), .rd_ce_n(rd_ce_n),
        .rd_oe_n(rd_oe_n), .rd_addr(rd_addr), .array_data(array_data),
        .rd_data(rd_data), .rd_valid(rd_valid), .rb_out_n(rb_out_n), .rb_oe(rb_oe)
    );

    // Wired-OR style line with a pull-up
    assign rb_line = rb_oe ? rb_out_n : 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DW-1:0] exp_word(bit busy, bit erase, bit hit,
                                               logic poll, logic [DW-1:0] ad);
        logic [DW-1:0] w;
        w = ad;
        if (busy) begin
            if (erase) w[7] = 1'b0;
            else if (hit) w[7] = ~poll;
        end
        return w;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s%s actual=%h expected=%h t=%0t", req, ctx, act, exp, $time);
        end
    endtask

    // One clock cycle: apply inputs, advance the model, check after the edge
    task automatic cyc(input logic st, input logic er, input logic [AW-1:0] oa,
                       input logic op, input logic ce, input logic oe,
                       input logic [AW-1:0] ra, input logic [DW-1:0] ad);
        bit acc;
        bit astart;
        logic [DW-1:0] mask;
        string req;
        op_start = st; op_erase = er; op_addr = oa; op_poll_src = op;
        rd_ce_n = ce; rd_oe_n = oe; rd_addr = ra; array_data = ad;
        acc = !ce && !oe;
        astart = acc && !m_accq;
        cap_now = 0;
        if (astart) begin
            m_snap = exp_word(m_busy, m_erase, ra == m_addr, m_poll, ad);
            m_snap_busy = m_busy;
            m_snap_erase = m_erase;
            cap_now = 1;
        end
        m_accq = acc;
        if (m_busy) begin
            if (m_cnt == 0) m_busy = 0;
            else m_cnt--;
        end else if (st) begin
            m_busy = 1; m_erase = er;
            m_cnt = er ? ERASE_LEN - 1 : PROG_LEN - 1;
            m_addr = oa; m_poll = op; have_prev = 0;
        end
        @(posedge clk);
        @(negedge clk);
        chk(rb_oe == m_busy, "R5", 32'(rb_oe), 32'(m_busy));
        chk(rb_line == !m_busy, "R5", 32'(rb_line), 32'(!m_busy));
        chk(rd_valid == m_accq, "R9", 32'(rd_valid), 32'(m_accq));
        if (!m_accq) begin
            chk(rd_data == '0, "R9", 32'(rd_data), 32'd0);
        end else begin
            mask = m_snap_busy ? 8'hBF : 8'hFF;
            req = m_snap_busy ? (m_snap_erase ? "R2" : "R1") : "R4";
            chk((rd_data & mask) == (m_snap & mask), req, 32'(rd_data), 32'(m_snap));
            if (cap_now && m_snap_busy) begin
                if (have_prev) chk(rd_data[6] == ~prev_b6, "R3", 32'(rd_data[6]), 32'(~prev_b6));
                prev_b6 = rd_data[6];
                have_prev = 1;
            end
        end
    endtask

    task automatic idle_cycles(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, '0, 0, 1, 1, '0, DW'($urandom));
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        logic [AW-1:0] a0;
        unused_seed = $urandom(32'h1F5E_ED42);

        // R10: reset state
        repeat (3) @(negedge clk);
        chk(rb_oe == 1'b0 && rb_out_n == 1'b1, "R10", {rb_oe, rb_out_n}, 32'b01);
        chk(rd_valid == 1'b0 && rd_data == '0, "R10", 32'(rd_data), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rb_oe == 1'b0 && rd_valid == 1'b0, "R10", {rb_oe, rd_valid}, 32'd0);
        idle_cycles(2);

        // R4: idle reads return exact array data
        ctx = " idle read R4";
        cyc(0, 0, '0, 0, 0, 0, 19'h00123, 8'hC5);
        cyc(0, 0, '0, 0, 1, 1, '0, 8'h00);
        cyc(0, 0, '0, 0, 0, 0, 19'h00124, 8'h40);
        cyc(0, 0, '0, 0, 1, 1, '0, 8'h00);

        // R6 and R1: read on the first busy cycle, program address hit
        ctx = " first read R6";
        a0 = 19'h05555;
        cyc(1, 0, a0, 1'b1, 1, 1, '0, 8'h00);
        cyc(0, 0, '0, 0, 0, 0, a0, 8'hFF);
        cyc(0, 0, '0, 0, 1, 1, '0, 8'h00);
        ctx = " program miss R1";
        cyc(0, 0, '0, 0, 0, 0, a0 + 1, 8'h80);
        cyc(0, 0, '0, 0, 1, 1, '0, 8'h00);
        // R3 via output enable only, chip enable held low
        ctx = " oe strobe R3";
        cyc(0, 0, '0, 0, 0, 0, a0, 8'h2A);
        cyc(0, 0, '0, 0, 0, 1, a0, 8'h2A);
        cyc(0, 0, '0, 0, 0, 0, a0, 8'h2A);
        cyc(0, 0, '0, 0, 1, 1, '0, 8'h00);
        while (m_busy) cyc(0, 0, '0, 0, 1, 1, '0, 8'h00);
        ctx = " after program R4";
        cyc(0, 0, '0, 0, 0, 0, a0, 8'h7F);
        cyc(0, 0, '0, 0, 1, 1, '0, 8'h00);

        // R2, R8, R7: erase with a held read and stray starts
        ctx = " erase held R8";
        cyc(1, 1, 19'h02000, 1'b0, 1, 1, '0, 8'h00);
        for (int i = 0; i < 5; i++) cyc(0, 0, '0, 0, 0, 0, 19'h7ABCD, DW'($urandom));
        cyc(0, 0, '0, 0, 1, 1, '0, 8'h00);
        cyc(0, 0, '0, 0, 0, 0, 19'h00002, 8'hFF);
        cyc(0, 0, '0, 0, 1, 1, '0, 8'h00);
        ctx = " stray start R7";
        cyc(1, 0, 19'h01111, 1'b1, 1, 1, '0, 8'h00);
        cyc(1, 0, 19'h01111, 1'b1, 0, 0, 19'h01111, 8'hFF);
        cyc(0, 0, '0, 0, 1, 1, '0, 8'h00);
        while (m_busy) cyc(0, 0, '0, 0, 1, 1, '0, 8'h00);
        cyc(0, 0, '0, 0, 0, 0, 19'h01111, 8'hA5);
        cyc(0, 0, '0, 0, 1, 1, '0, 8'h00);
        ctx = "";

        // Constrained random operations
        for (int op = 0; op < 150; op++) begin
            logic          er;
            logic [AW-1:0] oa;
            int            tail;
            er = 1'($urandom_range(0, 1));
            oa = AW'($urandom);
            cyc(1, er, oa, 1'($urandom), 1, 1, '0, DW'($urandom));
            tail = 0;
            while (m_busy || tail < 3) begin
                int on_len;
                int off_len;
                logic [AW-1:0] ra;
                bit use_ce;
                on_len  = $urandom_range(1, 3);
                off_len = $urandom_range(1, 2);
                ra      = ($urandom_range(0, 1) == 1) ? oa : AW'($urandom);
                use_ce  = 1'($urandom_range(0, 1));
                for (int k = 0; k < on_len; k++) begin
                    bit stray;
                    stray = m_busy && ($urandom_range(0, 7) == 0);
                    cyc(stray, 1'($urandom), AW'($urandom), 1'($urandom), 0, 0, ra, DW'($urandom));
                end
                for (int k = 0; k < off_len; k++) begin
                    cyc(0, 0, '0, 0, use_ce ? 1'b1 : 1'b0, use_ce ? 1'b0 : 1'b1, ra, DW'($urandom));
                end
                if (!m_busy) tail++;
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule